// File: doc/BRIEF.md
# Synchronizable Auxiliary DAC Register Bank

This block holds the control words for a set of auxiliary DAC channels (three by default, 8 bits each) and drives the output code that each analog DAC would convert. A host writes and reads the words and a few control registers over a simple parallel bus: a write strobe, an address, write data and combinational read data.

In direct mode a written word reaches its channel output on the clock edge that completes the write. In slave mode a written word is only staged. The outputs move when the host writes one-shot release bits, so any chosen subset of channels can change on the same clock edge. Each channel also has an invert control, which outputs the bitwise complement of the word. It also has a power-down control, which forces the output code to zero while the stored word is kept.

Register map (address: content): 0 word A, 1 word B, 2 word C, 3 update register, 4 power-down register, 5 invert register. Unmapped addresses read 0.

Top module: `auxdac_bank`

## Requirements
- R1: After a synchronous active-low reset, all output codes are 0, all words read back 0, and the update, power-down and invert registers read back 0.
- R2: With slave enable 0, writing a word (addresses 0, 1, 2 for A, B, C) changes that channel's output code to the new word on the clock edge of the write; the other channels are unchanged.
- R3: With slave enable 1, writing a word leaves every output code unchanged.
- R4: Writing the update register (address 3) with bit 7 set sets slave enable, and bits 2, 1, 0 of that write copy the staged word of channels C, B, A to their outputs. Several bits in one write change all the chosen outputs on the same edge.
- R5: Reading the update register returns slave enable in bit 7 and 0 in every other bit; the release bits always read back 0.
- R6: Writing the update register with bit 7 clear while slave enable is 1 clears slave enable and copies every staged word to its output on that edge.
- R7: Power-down register (address 4) bits 2, 1, 0 force the output code of channels C, B, A to 0. The stored word is kept and appears again when the bit is cleared.
- R8: Invert register (address 5) bits 4, 2, 0 make channels C, B, A output the bitwise complement of their word.
- R9: Reading a word address returns the last written word, not the inverted, powered-down or not-yet-released output code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| dac_code_a | output | 8 | Output code of channel A |
| dac_code_b | output | 8 | Output code of channel B |
| dac_code_c | output | 8 | Output code of channel C |

## Verification
The bench targets three corner cases. First, a release of two channels in one write: a design that handled the bits one at a time would show one output a cycle late. Second, leaving slave mode with staged words still pending: a design that dropped them would keep old codes on the outputs. Third, a power-down or invert applied over a stored word: a design that overwrote the word would read back or restore the wrong value. It also checks that a word written in slave mode leaves the outputs alone, that the release bits read back 0, and that direct-mode writes touch only the addressed channel.

// File: rtl/auxdac_pkg.sv
// Package: shared register addresses and sizes for the auxiliary DAC bank.
// Assumes a flat map of word registers at 0..NUM_CH-1 followed by controls.
package auxdac_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_WORD_A = 3'd0,
        REG_WORD_B = 3'd1,
        REG_WORD_C = 3'd2,
        REG_UPDATE = 3'd3,
        REG_PWRDN  = 3'd4,
        REG_INVERT = 3'd5
    } reg_addr_e;
endpackage

// File: rtl/auxdac_ctrl.sv
// Control register decode: holds slave enable, power-down and invert
// state, produces per-channel word write strobes and one-cycle release
// strobes. Assumes word registers sit at addresses 0..NUM_CH-1.
module auxdac_ctrl
    import auxdac_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [NUM_CH-1:0] word_wr,
    output logic [NUM_CH-1:0] release_ch,
    output logic              slave_q,
    output logic [NUM_CH-1:0] pwrdn_q,
    output logic [NUM_CH-1:0] inv_q,
    output logic              ctl_hit,
    output logic [WORD_W-1:0] ctl_rdata
);
    localparam int SLAVE_BIT = WORD_W - 1;

    logic upd_wr, pd_wr, inv_wr;
    logic new_slave;

    // Purpose: decode which control register a write targets.
    always_comb begin
        upd_wr    = bus_wr && (bus_addr == REG_UPDATE);
        pd_wr     = bus_wr && (bus_addr == REG_PWRDN);
        inv_wr    = bus_wr && (bus_addr == REG_INVERT);
        new_slave = bus_wdata[SLAVE_BIT];
    end

    genvar i;
    generate
        for (i = 0; i < NUM_CH; i++) begin : g_strobe
            // Purpose: per-channel word strobe and release strobe.
            always_comb begin
                word_wr[i]    = bus_wr && (bus_addr == ADDR_W'(i));
                release_ch[i] = upd_wr && (new_slave ? bus_wdata[i] : slave_q);
            end
        end
    endgenerate

    // Purpose: hold slave enable, power-down and invert state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slave_q <= 1'b0;
            pwrdn_q <= '0;
            inv_q   <= '0;
        end else begin
            if (upd_wr) slave_q <= new_slave;
            if (pd_wr)  pwrdn_q <= bus_wdata[NUM_CH-1:0];
            if (inv_wr) begin
                for (int k = 0; k < NUM_CH; k++) inv_q[k] <= bus_wdata[2*k];
            end
        end
    end

    // Purpose: read mux for control registers; release bits read as 0.
    always_comb begin
        ctl_hit   = 1'b1;
        ctl_rdata = '0;
        case (bus_addr)
            REG_UPDATE: ctl_rdata[SLAVE_BIT] = slave_q;
            REG_PWRDN:  ctl_rdata[NUM_CH-1:0] = pwrdn_q;
            REG_INVERT: for (int k = 0; k < NUM_CH; k++) ctl_rdata[2*k] = inv_q[k];
            default:    ctl_hit = 1'b0;
        endcase
    end

    // R6: leaving slave mode releases every channel on that edge
    assert_exit_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (slave_q && upd_wr && !new_slave) |-> (&release_ch));
endmodule

// File: rtl/auxdac_channel.sv
// One DAC channel: a staging register written by the bus and a live
// register feeding the output. Direct mode loads both at once; slave
// mode loads the live register only on a release strobe. Output code
// applies invert then power-down. Assumes strobes last one cycle.
module auxdac_channel #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_wr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              slave,
    input  logic              release_ch,
    input  logic              pwrdn,
    input  logic              inv,
    output logic [WORD_W-1:0] stored,
    output logic [WORD_W-1:0] code
);
    logic [WORD_W-1:0] stage_q, live_q;

    // Purpose: capture bus writes into the staging register.
    always_ff @(posedge clk) begin
        if (!rst_n)       stage_q <= '0;
        else if (word_wr) stage_q <= wdata;
    end

    // Purpose: update the live word directly or on a release strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)                 live_q <= '0;
        else if (word_wr && !slave) live_q <= wdata;
        else if (release_ch)        live_q <= stage_q;
    end

    // Purpose: form the output code and the readback value.
    always_comb begin
        stored = stage_q;
        if (pwrdn)    code = '0;
        else if (inv) code = ~live_q;
        else          code = live_q;
    end

    // R2: direct-mode write lands on the live word at the write edge
    assert_direct_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (word_wr && !slave) |=> (live_q == $past(wdata)));
    // R3: in slave mode the live word moves only on a release
    assert_staged_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (slave && !release_ch) |=> $stable(live_q));
    // R4: a release copies the staged word
    assert_release_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (release_ch && !word_wr) |=> (live_q == $past(stage_q)));
endmodule

// File: rtl/auxdac_bank.sv
// Top of the auxiliary DAC register bank: control decode plus a
// generated array of channels, and the bus read mux. Assumes a single
// master issuing one-cycle writes; reads are combinational.
module auxdac_bank
    import auxdac_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [2:0]        bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic [7:0]        dac_code_a,
    output logic [7:0]        dac_code_b,
    output logic [7:0]        dac_code_c
);
    logic [NUM_CH-1:0] word_wr, release_ch, pwrdn_q, inv_q;
    logic              slave_q, ctl_hit;
    logic [WORD_W-1:0] ctl_rdata;
    logic [WORD_W-1:0] stored [NUM_CH];
    logic [WORD_W-1:0] code   [NUM_CH];

    auxdac_ctrl #(.NUM_CH(NUM_CH), .WORD_W(WORD_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .word_wr(word_wr), .release_ch(release_ch),
        .slave_q(slave_q), .pwrdn_q(pwrdn_q), .inv_q(inv_q),
        .ctl_hit(ctl_hit), .ctl_rdata(ctl_rdata)
    );

    genvar i;
    generate
        for (i = 0; i < NUM_CH; i++) begin : g_ch
            auxdac_channel #(.WORD_W(WORD_W)) u_ch (
                .clk(clk), .rst_n(rst_n), .word_wr(word_wr[i]),
                .wdata(bus_wdata), .slave(slave_q), .release_ch(release_ch[i]),
                .pwrdn(pwrdn_q[i]), .inv(inv_q[i]),
                .stored(stored[i]), .code(code[i])
            );
            // R7: a powered-down channel drives code 0
            assert_pwrdn_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
                pwrdn_q[i] |-> (code[i] == '0));
        end
    endgenerate

    // Purpose: bus read mux over word registers and control registers.
    always_comb begin
        bus_rdata = '0;
        if (ctl_hit) bus_rdata = ctl_rdata;
        else begin
            for (int k = 0; k < NUM_CH; k++)
                if (bus_addr == 3'(k)) bus_rdata = stored[k];
        end
    end

    // Purpose: map channel codes to named output ports.
    always_comb begin
        dac_code_a = code[0];
        dac_code_b = code[1];
        dac_code_c = code[2];
    end

    // R5: release bits never read back as 1
    assert_update_reads_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == REG_UPDATE) |-> (bus_rdata[WORD_W-2:0] == '0));
endmodule

// File: tb/tb_auxdac_bank.sv
module tb_auxdac_bank;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata, dac_code_a, dac_code_b, dac_code_c;

    always #4 clk = ~clk;

    auxdac_bank dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dac_code_a(dac_code_a), .dac_code_b(dac_code_b), .dac_code_c(dac_code_c)
    );

    typedef struct { logic [23:0] codes; string req; } exp_t;
    exp_t sb[$];
    int checks = 0, errors = 0;

    // reference model
    logic [7:0] m_stg [3];
    logic [7:0] m_live[3];
    logic       m_slave;
    logic [2:0] m_pd, m_inv;

    function automatic logic [7:0] m_code(int c);
        if (m_pd[c]) return 8'h00;
        return m_inv[c] ? ~m_live[c] : m_live[c];
    endfunction

    function automatic logic [23:0] m_all();
        return {m_code(2), m_code(1), m_code(0)};
    endfunction

    task automatic model_reset();
        for (int c = 0; c < 3; c++) begin m_stg[c] = 0; m_live[c] = 0; end
        m_slave = 0; m_pd = 0; m_inv = 0;
    endtask

    task automatic model_write(input logic [2:0] a, input logic [7:0] d);
        if (a < 3) begin
            m_stg[a] = d;
            if (!m_slave) m_live[a] = d;
        end else if (a == 3) begin
            if (d[7]) begin
                for (int c = 0; c < 3; c++) if (d[c]) m_live[c] = m_stg[c];
                m_slave = 1;
            end else begin
                if (m_slave) for (int c = 0; c < 3; c++) m_live[c] = m_stg[c];
                m_slave = 0;
            end
        end else if (a == 4) m_pd = d[2:0];
        else if (a == 5) m_inv = {d[4], d[2], d[0]};
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // driver: one write, then push the expected output codes
    task automatic wr(input logic [2:0] a, input logic [7:0] d, input string req);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_wr = 1'b0;
        model_write(a, d);
        sb.push_back('{codes: m_all(), req: req});
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        bus_addr = a;
        #1 check(req, {24'h0, bus_rdata}, {24'h0, exp});
    endtask

    // monitor: compare outputs one negedge after each write edge
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check(e.req, {8'h0, dac_code_c, dac_code_b, dac_code_a}, {8'h0, e.codes});
        end
    end

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 codes", {8'h0, dac_code_c, dac_code_b, dac_code_a}, 32'h0);
        for (int a = 0; a < 6; a++) rd(3'(a), 8'h00, "R1 readback");

        // R2 direct writes, one channel at a time
        wr(0, 8'h12, "R2 A");
        wr(1, 8'hA5, "R2 B");
        wr(2, 8'hFF, "R2 C");
        wr(0, 8'h00, "R2 A zero");
        rd(1, 8'hA5, "R9 B");

        // R3 slave mode staging
        wr(3, 8'h80, "R4 enter slave");
        rd(3, 8'h80, "R5 slave bit");
        wr(0, 8'h3C, "R3 A staged");
        wr(1, 8'h77, "R3 B staged");
        wr(2, 8'h01, "R3 C staged");
        rd(0, 8'h3C, "R9 staged A");
        // R4 release A and C together, B remains pending
        wr(3, 8'h85, "R4 release A,C");
        rd(3, 8'h80, "R5 update bits low");
        wr(3, 8'h82, "R4 release B");
        wr(1, 8'h99, "R3 B staged again");
        wr(0, 8'h44, "R3 A staged again");
        // R6 leave slave mode with pending words
        wr(3, 8'h00, "R6 exit slave");
        rd(3, 8'h00, "R5 slave cleared");

        // R7 power-down keeps word
        wr(4, 8'h05, "R7 pd A,C");
        rd(0, 8'h44, "R7 word kept");
        wr(0, 8'h5A, "R7 write while down");
        wr(4, 8'h00, "R7 restore");
        // R8 invert
        wr(5, 8'h15, "R8 invert all");
        rd(5, 8'h15, "R8 readback");
        rd(2, 8'h01, "R9 stored not inverted");
        wr(5, 8'h04, "R8 invert B only");
        wr(4, 8'h02, "R7 pd overrides invert");
        wr(4, 8'h00, "R7 clear");

        @(negedge clk);
        @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule